// File: doc/BRIEF.md
# Odd-Coefficient Pipeline of a Scaled 8-Point DCT

This block produces the four odd-index coefficients (1, 3, 5 and 7) of an eight-point scaled discrete cosine transform. It uses the fast factorisation in which every output still carries a per-index scale factor, which a later stage removes. Eight signed samples `x0`..`x7` arrive together on a clock where `in_valid` is high. Six clocks later the four scaled coefficients appear together with `out_valid`. A new vector may be accepted on every clock. The even half, the final descaling and any 2-D transposition belong to other blocks.

Each pipeline stage performs at most one add, one subtract or one constant multiply per node. Operands that skip a stage travel through delay registers, so every stage works on values from a single input vector. The arithmetic runs as follows. Stage 1 forms the mirror differences a4=x3-x4, a5=x2-x5, a6=x1-x6 and a7=x0-x7. Stage 2 forms the plain sums b4=a4+a5, b5=a5+a6 and b6=a6+a7, and delays a7 into b7. Stage 3 forms the rotation difference r=b6-b4 and delays b4..b7. Stage 4 applies the constant multiplies: m4=KA·b4, m5=KB·b5, m6=KC·b6 and mr=KD·r, and delays b7 into m7. Stage 5 forms e4=m4-mr, e6=m6-mr, e5=m7+m5 and e7=m7-m5. Stage 6 forms the outputs coef1=e5+e6, coef7=e5-e6, coef5=e7+e4 and coef3=e7-e4.

The constants are signed fixed-point integers with `FRAC_W` fraction bits, so the real value of a constant is K/2^FRAC_W. Their defaults are 8867 (KA, about 0.5412), 11585 (KB, about 0.7071), 21407 (KC, about 1.3066) and 6270 (KD, about 0.3827). Each product is rounded to the nearest integer and brought back to integer weight. The datapath widens by one bit at every add or subtract stage.

Top module: `aan_odd_dct`

## Requirements
- R1: After reset, and until the first result arrives, `out_valid` is 0 and all four coefficient outputs are 0.
- R2: `out_valid` equals `in_valid` as sampled six rising clock edges earlier.
- R3: `coef1` matches e5+e6, computed in real arithmetic from the constants K/2^FRAC_W, to within 1.5.
- R4: `coef7` matches e5-e6, computed the same way, to within 1.5.
- R5: `coef5` matches e7+e4, computed the same way, to within 1.5.
- R6: `coef3` matches e7-e4, computed the same way, to within 1.5.
- R7: When vectors are accepted on consecutive clocks, each result depends only on its own vector.
- R8: Full-scale inputs, meaning every sample at -2^(DATA_W-1) or 2^(DATA_W-1)-1, never wrap. Each output is DATA_W+5 bits wide and keeps its two top bits equal.
- R9: A mirror-symmetric vector, where x_i = x_(7-i) for all i, gives exactly 0 on all four outputs.
- R10: While `out_valid` is 0, the four coefficient outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector valid |
| x0 | input | DATA_W | Sample 0, signed |
| x1 | input | DATA_W | Sample 1, signed |
| x2 | input | DATA_W | Sample 2, signed |
| x3 | input | DATA_W | Sample 3, signed |
| x4 | input | DATA_W | Sample 4, signed |
| x5 | input | DATA_W | Sample 5, signed |
| x6 | input | DATA_W | Sample 6, signed |
| x7 | input | DATA_W | Sample 7, signed |
| out_valid | output | 1 | Result valid |
| coef1 | output | DATA_W+5 | Scaled coefficient 1, signed |
| coef3 | output | DATA_W+5 | Scaled coefficient 3, signed |
| coef5 | output | DATA_W+5 | Scaled coefficient 5, signed |
| coef7 | output | DATA_W+5 | Scaled coefficient 7, signed |

## Verification
The hardest situation to reach is a dense pipeline in which six vectors are in flight at once, with gaps placed so that a stage holding one vector sits beside a stage loading another. Only that case shows a delay register that loads on the wrong enable and pairs operands from different vectors. The stimulus runs long unbroken bursts for R7, then random valid patterns with frequent single-cycle gaps. It also uses directed vectors at full scale, alternating extremes and exact mirror symmetry. Each of these vectors is compared against a real-valued evaluation of the same stage equations.

// File: rtl/aan_odd_pkg.sv
package aan_odd_pkg;
    // register stages from input to output
    localparam int STAGES      = 6;
    // guard bits above the fraction for coefficients below 2.0
    localparam int COEF_GUARD  = 2;
    // default fixed-point constants at 14 fraction bits
    localparam int DEF_FRAC    = 14;
    localparam int DEF_KA      = 8867;   // about 0.5412
    localparam int DEF_KB      = 11585;  // about 0.7071
    localparam int DEF_KC      = 21407;  // about 1.3066
    localparam int DEF_KD      = 6270;   // about 0.3827
    localparam int NUM_MUL     = 4;
endpackage

// File: rtl/aan_odd_front.sv
// Stages 1 to 3: mirror differences, plain sums, rotation difference.
module aan_odd_front #(
    parameter int W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en1,
    input  logic                 en2,
    input  logic                 en3,
    input  logic signed [W-1:0]  x0,
    input  logic signed [W-1:0]  x1,
    input  logic signed [W-1:0]  x2,
    input  logic signed [W-1:0]  x3,
    input  logic signed [W-1:0]  x4,
    input  logic signed [W-1:0]  x5,
    input  logic signed [W-1:0]  x6,
    input  logic signed [W-1:0]  x7,
    output logic signed [W+1:0]  c4,
    output logic signed [W+1:0]  c5,
    output logic signed [W+1:0]  c6,
    output logic signed [W+1:0]  c7,
    output logic signed [W+2:0]  crot
);
    localparam int AW = W + 1;
    localparam int BW = W + 2;
    localparam int CW = W + 3;

    typedef struct packed {
        logic signed [AW-1:0] a4;
        logic signed [AW-1:0] a5;
        logic signed [AW-1:0] a6;
        logic signed [AW-1:0] a7;
        logic signed [BW-1:0] b4;
        logic signed [BW-1:0] b5;
        logic signed [BW-1:0] b6;
        logic signed [BW-1:0] b7;
        logic signed [BW-1:0] c4;
        logic signed [BW-1:0] c5;
        logic signed [BW-1:0] c6;
        logic signed [BW-1:0] c7;
        logic signed [CW-1:0] crot;
    } front_t;

    front_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en1) begin
            st_d.a4 = AW'(x3) - AW'(x4);
            st_d.a5 = AW'(x2) - AW'(x5);
            st_d.a6 = AW'(x1) - AW'(x6);
            st_d.a7 = AW'(x0) - AW'(x7);
        end
        if (en2) begin
            st_d.b4 = BW'(st_q.a4) + BW'(st_q.a5);
            st_d.b5 = BW'(st_q.a5) + BW'(st_q.a6);
            st_d.b6 = BW'(st_q.a6) + BW'(st_q.a7);
            st_d.b7 = BW'(st_q.a7);
        end
        if (en3) begin
            st_d.c4   = st_q.b4;
            st_d.c5   = st_q.b5;
            st_d.c6   = st_q.b6;
            st_d.c7   = st_q.b7;
            st_d.crot = CW'(st_q.b6) - CW'(st_q.b4);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c4   = st_q.c4;
    assign c5   = st_q.c5;
    assign c6   = st_q.c6;
    assign c7   = st_q.c7;
    assign crot = st_q.crot;
endmodule

// File: rtl/aan_odd_cmul.sv
// Registered constant multiply, rounded to nearest at integer weight.
module aan_odd_cmul
    import aan_odd_pkg::*;
#(
    parameter int IN_W  = 15,
    parameter int OUT_W = 15,
    parameter int FRAC  = 14,
    parameter int COEF  = 8867
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  a,
    output logic signed [OUT_W-1:0] y
);
    localparam int PW = IN_W + FRAC + COEF_GUARD;
    localparam logic signed [PW-1:0] KCONST = PW'(COEF);

    logic signed [PW-1:0]    rnd;
    logic signed [PW-1:0]    prod;
    logic signed [OUT_W-1:0] y_d, y_q;

    generate
        if (FRAC > 0) begin : g_round
            assign rnd = PW'(1) <<< (FRAC - 1);
        end else begin : g_exact
            assign rnd = '0;
        end
    endgenerate

    always_comb begin
        prod = PW'(a) * KCONST;
        y_d  = y_q;
        if (en) y_d = OUT_W'((prod + rnd) >>> FRAC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) y_q <= '0;
        else        y_q <= y_d;
    end

    assign y = y_q;
endmodule

// File: rtl/aan_odd_back.sv
// Stages 5 and 6: rotation merge and output butterflies.
module aan_odd_back #(
    parameter int W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en5,
    input  logic                 en6,
    input  logic signed [W+2:0]  m4,
    input  logic signed [W+2:0]  m5,
    input  logic signed [W+2:0]  m6,
    input  logic signed [W+2:0]  m7,
    input  logic signed [W+2:0]  mrot,
    output logic signed [W+4:0]  y1,
    output logic signed [W+4:0]  y3,
    output logic signed [W+4:0]  y5,
    output logic signed [W+4:0]  y7
);
    localparam int EW = W + 4;
    localparam int OW = W + 5;

    typedef struct packed {
        logic signed [EW-1:0] e4;
        logic signed [EW-1:0] e5;
        logic signed [EW-1:0] e6;
        logic signed [EW-1:0] e7;
        logic signed [OW-1:0] y1;
        logic signed [OW-1:0] y3;
        logic signed [OW-1:0] y5;
        logic signed [OW-1:0] y7;
    } back_t;

    back_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en5) begin
            st_d.e4 = EW'(m4) - EW'(mrot);
            st_d.e6 = EW'(m6) - EW'(mrot);
            st_d.e5 = EW'(m7) + EW'(m5);
            st_d.e7 = EW'(m7) - EW'(m5);
        end
        if (en6) begin
            st_d.y1 = OW'(st_q.e5) + OW'(st_q.e6);
            st_d.y7 = OW'(st_q.e5) - OW'(st_q.e6);
            st_d.y5 = OW'(st_q.e7) + OW'(st_q.e4);
            st_d.y3 = OW'(st_q.e7) - OW'(st_q.e4);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y1 = st_q.y1;
    assign y3 = st_q.y3;
    assign y5 = st_q.y5;
    assign y7 = st_q.y7;
endmodule

// File: rtl/aan_odd_dct.sv
module aan_odd_dct
    import aan_odd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int FRAC_W = DEF_FRAC,
    parameter int KA     = DEF_KA,
    parameter int KB     = DEF_KB,
    parameter int KC     = DEF_KC,
    parameter int KD     = DEF_KD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] x0,
    input  logic signed [DATA_W-1:0] x1,
    input  logic signed [DATA_W-1:0] x2,
    input  logic signed [DATA_W-1:0] x3,
    input  logic signed [DATA_W-1:0] x4,
    input  logic signed [DATA_W-1:0] x5,
    input  logic signed [DATA_W-1:0] x6,
    input  logic signed [DATA_W-1:0] x7,
    output logic                     out_valid,
    output logic signed [DATA_W+4:0] coef1,
    output logic signed [DATA_W+4:0] coef3,
    output logic signed [DATA_W+4:0] coef5,
    output logic signed [DATA_W+4:0] coef7
);
    localparam int BW = DATA_W + 2;
    localparam int CW = DATA_W + 3;
    localparam int DW = DATA_W + 3;
    localparam int KS [NUM_MUL] = '{KA, KB, KC, KD};

    typedef struct packed {
        logic [STAGES-1:0]    v;
        logic signed [DW-1:0] m7;
    } ctl_t;

    ctl_t st_d, st_q;

    logic signed [BW-1:0] c4, c5, c6, c7;
    logic signed [CW-1:0] crot;
    logic signed [CW-1:0] mul_in  [NUM_MUL];
    logic signed [DW-1:0] mul_out [NUM_MUL];

    // stage enables: stage k loads when stage k-1 holds a valid vector
    logic en1, en2, en3, en4, en5, en6;
    assign en1 = in_valid;
    assign en2 = st_q.v[0];
    assign en3 = st_q.v[1];
    assign en4 = st_q.v[2];
    assign en5 = st_q.v[3];
    assign en6 = st_q.v[4];

    always_comb begin
        st_d   = st_q;
        st_d.v = {st_q.v[STAGES-2:0], in_valid};
        if (en4) st_d.m7 = DW'(c7);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    aan_odd_front #(.W(DATA_W)) u_front (
        .clk  (clk),
        .rst_n(rst_n),
        .en1  (en1),
        .en2  (en2),
        .en3  (en3),
        .x0   (x0),
        .x1   (x1),
        .x2   (x2),
        .x3   (x3),
        .x4   (x4),
        .x5   (x5),
        .x6   (x6),
        .x7   (x7),
        .c4   (c4),
        .c5   (c5),
        .c6   (c6),
        .c7   (c7),
        .crot (crot)
    );

    assign mul_in[0] = CW'(c4);
    assign mul_in[1] = CW'(c5);
    assign mul_in[2] = CW'(c6);
    assign mul_in[3] = crot;

    generate
        for (genvar i = 0; i < NUM_MUL; i++) begin : g_mul
            aan_odd_cmul #(
                .IN_W (CW),
                .OUT_W(DW),
                .FRAC (FRAC_W),
                .COEF (KS[i])
            ) u_mul (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (en4),
                .a    (mul_in[i]),
                .y    (mul_out[i])
            );
        end
    endgenerate

    aan_odd_back #(.W(DATA_W)) u_back (
        .clk  (clk),
        .rst_n(rst_n),
        .en5  (en5),
        .en6  (en6),
        .m4   (mul_out[0]),
        .m5   (mul_out[1]),
        .m6   (mul_out[2]),
        .m7   (st_q.m7),
        .mrot (mul_out[3]),
        .y1   (coef1),
        .y3   (coef3),
        .y5   (coef5),
        .y7   (coef7)
    );

    assign out_valid = st_q.v[STAGES-1];
endmodule

// File: rtl/aan_odd_dct_chk.sv
module aan_odd_dct_chk #(
    parameter int DATA_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] x0,
    input logic signed [DATA_W-1:0] x1,
    input logic signed [DATA_W-1:0] x2,
    input logic signed [DATA_W-1:0] x3,
    input logic signed [DATA_W-1:0] x4,
    input logic signed [DATA_W-1:0] x5,
    input logic signed [DATA_W-1:0] x6,
    input logic signed [DATA_W-1:0] x7,
    input logic                     out_valid,
    input logic signed [DATA_W+4:0] coef1,
    input logic signed [DATA_W+4:0] coef3,
    input logic signed [DATA_W+4:0] coef5,
    input logic signed [DATA_W+4:0] coef7
);
    localparam int OW = DATA_W + 5;

    logic mirror;
    assign mirror = (x0 == x7) && (x1 == x6) && (x2 == x5) && (x3 == x4);

    a_r2_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##6 out_valid);

    a_r2_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##6 !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(coef1) && $stable(coef3) && $stable(coef5) && $stable(coef7)));

    a_r9_mirror_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mirror) |-> ##6 (coef1 == '0 && coef3 == '0 && coef5 == '0 && coef7 == '0));

    a_r8_headroom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((coef1[OW-1] == coef1[OW-2]) && (coef3[OW-1] == coef3[OW-2]) &&
                       (coef5[OW-1] == coef5[OW-2]) && (coef7[OW-1] == coef7[OW-2])));
endmodule

bind aan_odd_dct aan_odd_dct_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .x0       (x0),
    .x1       (x1),
    .x2       (x2),
    .x3       (x3),
    .x4       (x4),
    .x5       (x5),
    .x6       (x6),
    .x7       (x7),
    .out_valid(out_valid),
    .coef1    (coef1),
    .coef3    (coef3),
    .coef5    (coef5),
    .coef7    (coef7)
);

// File: tb/aan_odd_dct_tb.sv
module aan_odd_dct_tb;
    localparam int W    = 12;
    localparam int OW   = W + 5;
    localparam int FR   = 14;
    localparam int LAT  = 6;
    localparam real TOL = 1.5 + 1.0e-6;
    localparam int MAXV = (1 << (W - 1)) - 1;
    localparam int MINV = -(1 << (W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] xs [8];
    logic out_valid;
    logic signed [OW-1:0] coef1, coef3, coef5, coef7;

    always #2 clk = ~clk;   // 250 MHz

    aan_odd_dct u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x0(xs[0]), .x1(xs[1]), .x2(xs[2]), .x3(xs[3]),
        .x4(xs[4]), .x5(xs[5]), .x6(xs[6]), .x7(xs[7]),
        .out_valid(out_valid),
        .coef1(coef1), .coef3(coef3), .coef5(coef5), .coef7(coef7)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  finished = 0;
    int  cur [8];
    int  hx  [8][8];
    bit  hv  [8];
    bit  hb  [8];   // applied during a back-to-back burst
    bit  hf  [8];   // full-scale vector
    bit  burst = 0;
    bit  fscale = 0;
    logic signed [OW-1:0] prev1 = '0, prev3 = '0, prev5 = '0, prev7 = '0;

    task automatic chk_int(string tag, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic chk_real(string tag, real got, real exp);
        real d;
        n_chk++;
        d = got - exp;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            n_bad++;
            $display("FAIL %s: got %0f expected %0f (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // real evaluation of the stage equations
    task automatic model(input int v[8], output real o1, output real o3,
                         output real o5, output real o7);
        real ka, kb, kc, kd;
        real a4, a5, a6, a7, b4, b5, b6, b7, r, m4, m5, m6, m7, mr, e4, e5, e6, e7;
        ka = 8867.0 / 16384.0;
        kb = 11585.0 / 16384.0;
        kc = 21407.0 / 16384.0;
        kd = 6270.0 / 16384.0;
        a4 = v[3] - v[4]; a5 = v[2] - v[5]; a6 = v[1] - v[6]; a7 = v[0] - v[7];
        b4 = a4 + a5; b5 = a5 + a6; b6 = a6 + a7; b7 = a7;
        r  = b6 - b4;
        m4 = ka * b4; m5 = kb * b5; m6 = kc * b6; m7 = b7; mr = kd * r;
        e4 = m4 - mr; e6 = m6 - mr; e5 = m7 + m5; e7 = m7 - m5;
        o1 = e5 + e6; o7 = e5 - e6; o5 = e7 + e4; o3 = e7 - e4;
    endtask

    task automatic check_slot();
        int  s;
        real o1, o3, o5, o7;
        string pre;
        bit exp_v;
        bit mir;
        s = (cyc - LAT) & 7;
        exp_v = (cyc >= LAT) ? hv[s] : 1'b0;
        chk_int("R2 out_valid", longint'(out_valid), longint'(exp_v));
        if (exp_v && out_valid) begin
            model(hx[s], o1, o3, o5, o7);
            pre = hb[s] ? "R7 " : "";
            if (hf[s]) pre = {pre, "R8 "};
            chk_real({pre, "R3 coef1"}, $itor(coef1), o1);
            chk_real({pre, "R4 coef7"}, $itor(coef7), o7);
            chk_real({pre, "R5 coef5"}, $itor(coef5), o5);
            chk_real({pre, "R6 coef3"}, $itor(coef3), o3);
            if (hf[s]) chk_int("R8 headroom coef1",
                               longint'(coef1[OW-1] == coef1[OW-2]), 1);
            mir = 1'b1;
            for (int i = 0; i < 4; i++) if (hx[s][i] != hx[s][7-i]) mir = 1'b0;
            if (mir) begin
                chk_int("R9 coef1 zero", longint'(coef1), 0);
                chk_int("R9 coef3 zero", longint'(coef3), 0);
                chk_int("R9 coef5 zero", longint'(coef5), 0);
                chk_int("R9 coef7 zero", longint'(coef7), 0);
            end
        end else if (!out_valid) begin
            chk_int("R10 coef1 hold", longint'(coef1), longint'(prev1));
            chk_int("R10 coef5 hold", longint'(coef5), longint'(prev5));
        end
        prev1 = coef1; prev3 = coef3; prev5 = coef5; prev7 = coef7;
    endtask

    // one clock: check at falling edge, then drive the next inputs
    task automatic step(input bit v);
        @(negedge clk);
        check_slot();
        in_valid = v;
        for (int i = 0; i < 8; i++) xs[i] = W'(cur[i]);
        hv[cyc & 7] = v;
        hb[cyc & 7] = burst;
        hf[cyc & 7] = fscale;
        for (int i = 0; i < 8; i++) hx[cyc & 7][i] = cur[i];
        cyc++;
    endtask

    task automatic rand_vec();
        for (int i = 0; i < 8; i++) cur[i] = int'($urandom_range(0, (1 << W) - 1)) + MINV;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            hv[i] = 0; hb[i] = 0; hf[i] = 0; cur[i] = 0; xs[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        // R1: reset state while held and after release
        @(negedge clk);
        chk_int("R1 out_valid in reset", longint'(out_valid), 0);
        chk_int("R1 coef1 in reset", longint'(coef1), 0);
        chk_int("R1 coef3 in reset", longint'(coef3), 0);
        rst_n = 1'b1;
        repeat (3) step(1'b0);
        chk_int("R1 coef5 idle", longint'(coef5), 0);
        chk_int("R1 coef7 idle", longint'(coef7), 0);

        // directed corner cases
        fscale = 1;
        for (int i = 0; i < 8; i++) cur[i] = (i < 4) ? MAXV : MINV;
        step(1'b1);
        for (int i = 0; i < 8; i++) cur[i] = (i < 4) ? MINV : MAXV;
        step(1'b1);
        for (int i = 0; i < 8; i++) cur[i] = (i % 2 == 0) ? MAXV : MINV;
        step(1'b1);
        for (int i = 0; i < 8; i++) cur[i] = (i % 2 == 0) ? MINV : MAXV;
        step(1'b1);
        for (int i = 0; i < 8; i++) cur[i] = ((i == 0) || (i == 2) || (i == 5) || (i == 7)) ? MAXV : MINV;
        step(1'b1);
        fscale = 0;
        for (int i = 0; i < 8; i++) cur[i] = 0;
        cur[0] = 1000;
        step(1'b1);
        for (int i = 0; i < 8; i++) cur[i] = 0;
        cur[3] = -777;
        step(1'b1);
        // R9: mirror-symmetric vectors
        for (int i = 0; i < 4; i++) begin
            cur[i] = 100 * i - 900;
            cur[7-i] = cur[i];
        end
        step(1'b1);
        for (int i = 0; i < 4; i++) begin
            cur[i] = (i % 2) ? MAXV : MINV;
            cur[7-i] = cur[i];
        end
        step(1'b0);
        step(1'b1);
        repeat (8) step(1'b0);

        // R7: long back-to-back bursts of random vectors
        burst = 1;
        for (int k = 0; k < 400; k++) begin
            rand_vec();
            step(1'b1);
        end
        burst = 0;
        repeat (8) step(1'b0);

        // random gaps, with occasional mirrored vectors
        for (int k = 0; k < 3000; k++) begin
            rand_vec();
            if ($urandom_range(0, 9) == 0)
                for (int i = 0; i < 4; i++) cur[7-i] = cur[i];
            step($urandom_range(0, 3) != 0);
        end
        repeat (10) step(1'b0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule